// File: doc/BRIEF.md
# Windowed Direct-Mapped Instruction Cache

This block sits between a 32-bit processor fetch port and a plain word-read memory port. It holds recently fetched instruction words in a direct-mapped store and answers repeated fetches without going to memory. Only one address window can be cached. The window is a power of two in size and starts at a base that is aligned to that size. Any fetch outside the window goes to memory every time and leaves the cache untouched.

Each line entry holds a short tag, a line-valid flag and one valid flag per word. The tag only has to tell apart the positions of the cache inside the window, not the whole 32-bit space. A miss fills only the word that was asked for, so a line can stay partly filled. A tag mismatch reallocates the line and discards all of its words. A one-cycle invalidate pulse starts a walk that clears the line-valid flag of every line, one line per clock.

Top module: `ifetch_cache`

## Requirements
- R1: An address is cacheable exactly when its bits above WIN_LOG2 equal those of WIN_BASE. With the defaults (base 0x0030_0000, WIN_LOG2=16) the window is 0x0030_0000..0x0030_FFFC. WIN_BASE-4 and WIN_BASE+0x10000 are not cacheable.
- R2: The byte address is split as follows: word select = bits [LINE_LOG2-1:2], line index = bits [CACHE_LOG2-1:LINE_LOG2], tag = bits [WIN_LOG2-1:CACHE_LOG2]. With the defaults (4 KB cache, 8-word lines) this gives 128 lines, a 4-bit tag and 1024 words. Two cacheable addresses that share an index but differ in tag evict each other.
- R3: A fetch hits when three conditions hold: the line is valid, the stored tag equals the address tag, and the addressed word is valid. On a hit, rsp_valid_o is high in the cycle right after the handshake and no memory read is issued.
- R4: A cacheable fetch whose line is invalid or holds another tag reallocates the line. The new tag is written, the line is marked valid and every word flag is cleared. Then the single word is fetched. Words that were cached in the old line miss afterwards.
- R5: A cacheable fetch of an invalid word in a valid line with a matching tag reads only that word from memory. The other valid words of the line still hit afterwards.
- R6: A fetch that goes to memory returns the memory word on rsp_data_o. rsp_valid_o is high in the cycle after the cycle in which mem_ack_i was sampled high.
- R7: A non-cacheable fetch issues one memory read every time and changes no cache state. A cached line at the same index still hits afterwards.
- R8: A one-cycle pulse on inval_i clears the line-valid flag of every line. req_ready_o is low from the cycle in which the pulse is applied through the LINES cycles that follow. After the walk, every previously cached address misses.
- R9: At most one memory read is outstanding. mem_rd_o and mem_addr_o stay unchanged until mem_ack_i. mem_addr_o always has bits [1:0] = 0 and equals the fetch address with those bits cleared.
- R10: After reset, req_ready_o is high, rsp_valid_o and mem_rd_o are low, and all lines are invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inval_i | input | 1 | One-cycle pulse that starts the invalidate walk |
| req_valid_i | input | 1 | Fetch request valid |
| req_ready_o | output | 1 | Cache can accept a fetch this cycle |
| req_addr_i | input | 32 | Fetch byte address |
| rsp_valid_o | output | 1 | Fetch response valid (one cycle) |
| rsp_data_o | output | 32 | Fetched instruction word |
| mem_rd_o | output | 1 | Memory word read request, held until acknowledged |
| mem_addr_o | output | 32 | Word-aligned memory read address |
| mem_ack_i | input | 1 | Memory read acknowledge, data valid this cycle |
| mem_data_i | input | 32 | Memory read data |

## Verification
Directed fetch sequences first target one line. A cold miss must reallocate. A repeat must hit in one cycle. A neighbouring word must fill only itself. An aliasing tag must evict the line and drop the words it had filled. Boundary addresses just below, at the first and last word of, and just past the window separate the cacheable decode from bypass, and a bypass that aliases a cached index shows that bypass leaves the cache alone. Random fetches are drawn from a few tags and indices, mixed with out-of-window and unaligned addresses, varying memory latency and invalidate pulses. A bench model of the tags and valid flags predicts hit or miss, the number of memory reads and the response timing for each fetch.

// File: rtl/ifc_pkg.sv
package ifc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_MEMRD,
    ST_RESP,
    ST_INVAL
  } ifc_state_e;
endpackage

// File: rtl/ifc_addr_split.sv
module ifc_addr_split #(
  parameter int          ADDR_W     = 32,
  parameter logic [31:0] WIN_BASE   = 32'h0030_0000,
  parameter int          WIN_LOG2   = 16,
  parameter int          CACHE_LOG2 = 12,
  parameter int          WSEL_W     = 3,
  localparam int         LINE_LOG2  = WSEL_W + 2,
  localparam int         INDEX_W    = CACHE_LOG2 - LINE_LOG2,
  localparam int         TAG_W      = WIN_LOG2 - CACHE_LOG2
) (
  input  logic [ADDR_W-1:2]  waddr_i,
  output logic               cacheable_o,
  output logic [TAG_W-1:0]   tag_o,
  output logic [INDEX_W-1:0] index_o,
  output logic [WSEL_W-1:0]  wsel_o
);
  always_comb begin
    cacheable_o = (waddr_i[ADDR_W-1:WIN_LOG2] == WIN_BASE[ADDR_W-1:WIN_LOG2]);
    tag_o       = waddr_i[WIN_LOG2-1:CACHE_LOG2];
    index_o     = waddr_i[CACHE_LOG2-1:LINE_LOG2];
    wsel_o      = waddr_i[LINE_LOG2-1:2];
  end
endmodule

// File: rtl/ifc_tag_store.sv
module ifc_tag_store #(
  parameter int  INDEX_W = 7,
  parameter int  TAG_W   = 4,
  parameter int  WSEL_W  = 3,
  localparam int LINES   = 1 << INDEX_W,
  localparam int WORDS_PER_LINE = 1 << WSEL_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [INDEX_W-1:0] idx_i,
  input  logic [TAG_W-1:0]   tag_i,
  input  logic [WSEL_W-1:0]  wsel_i,
  input  logic               alloc_en_i,
  input  logic               wset_en_i,
  input  logic               inval_en_i,
  input  logic [INDEX_W-1:0] inval_idx_i,
  output logic               line_match_o,
  output logic               word_valid_o
);
  logic [LINES-1:0]          lv_q, lv_d;
  logic [TAG_W-1:0]          tag_q [LINES];
  logic [WORDS_PER_LINE-1:0] wv_q  [LINES];

  always_comb begin
    lv_d = lv_q;
    if (alloc_en_i) lv_d[idx_i] = 1'b1;
    if (inval_en_i) lv_d[inval_idx_i] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lv_q <= '0;
    else        lv_q <= lv_d;
  end

  always_ff @(posedge clk) begin
    if (alloc_en_i) begin
      tag_q[idx_i] <= tag_i;
      wv_q[idx_i]  <= '0;
    end else if (wset_en_i) begin
      wv_q[idx_i][wsel_i] <= 1'b1;
    end
  end

  always_comb begin
    line_match_o = lv_q[idx_i] && (tag_q[idx_i] == tag_i);
    word_valid_o = wv_q[idx_i][wsel_i];
  end

  // R5
  fill_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wset_en_i |-> line_match_o);
  // R4
  alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en_i |=> (line_match_o && !word_valid_o));
  // R8
  inval_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inval_en_i |=> (lv_q[$past(inval_idx_i)] == 1'b0));
endmodule

// File: rtl/ifc_data_store.sv
module ifc_data_store #(
  parameter int  AW     = 10,
  parameter int  DATA_W = 32,
  localparam int DEPTH  = 1 << AW
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/ifc_ctrl.sv
module ifc_ctrl
  import ifc_pkg::*;
#(
  parameter int  INDEX_W = 7,
  localparam int LINES   = 1 << INDEX_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               inval_i,
  input  logic               req_valid_i,
  input  logic               cacheable_i,
  input  logic               line_match_i,
  input  logic               word_valid_i,
  input  logic               mem_ack_i,
  output logic               req_ready_o,
  output logic               accept_o,
  output logic               hit_o,
  output logic               rsp_from_mem_o,
  output logic               alloc_en_o,
  output logic               wset_en_o,
  output logic               resp_we_o,
  output logic               inval_en_o,
  output logic [INDEX_W-1:0] inval_idx_o,
  output logic               mem_rd_o
);
  ifc_state_e         state_q, state_d;
  logic [INDEX_W-1:0] cnt_q, cnt_d;
  logic               pend_q, pend_d;
  logic               pend_now;

  always_comb begin
    pend_now    = inval_i | pend_q;
    hit_o       = (state_q == ST_LOOKUP) && cacheable_i && line_match_i && word_valid_i;
    req_ready_o = !pend_now &&
                  ((state_q == ST_IDLE) || (state_q == ST_RESP) || hit_o);
    accept_o    = req_valid_i && req_ready_o;
    alloc_en_o  = (state_q == ST_LOOKUP) && cacheable_i && !line_match_i;
    mem_rd_o    = (state_q == ST_MEMRD);
    resp_we_o   = mem_rd_o && mem_ack_i;
    wset_en_o   = resp_we_o && cacheable_i;
    inval_en_o  = (state_q == ST_INVAL);
    inval_idx_o = cnt_q;
    rsp_from_mem_o = (state_q == ST_RESP);

    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (pend_now)         state_d = ST_INVAL;
        else if (req_valid_i) state_d = ST_LOOKUP;
      end
      ST_LOOKUP: begin
        if (!hit_o)           state_d = ST_MEMRD;
        else if (pend_now)    state_d = ST_INVAL;
        else if (req_valid_i) state_d = ST_LOOKUP;
        else                  state_d = ST_IDLE;
      end
      ST_MEMRD: begin
        if (mem_ack_i)        state_d = ST_RESP;
      end
      ST_RESP: begin
        if (pend_now)         state_d = ST_INVAL;
        else if (req_valid_i) state_d = ST_LOOKUP;
        else                  state_d = ST_IDLE;
      end
      ST_INVAL: begin
        if (cnt_q == INDEX_W'(LINES - 1)) state_d = ST_IDLE;
      end
      default:                state_d = ST_IDLE;
    endcase

    cnt_d  = (state_q == ST_INVAL) ? cnt_q + 1'b1 : '0;
    pend_d = ((state_d == ST_INVAL) && (state_q != ST_INVAL)) ? 1'b0 : (pend_q | inval_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      pend_q  <= pend_d;
    end
  end

  // R9
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_o && !mem_ack_i) |=> mem_rd_o);
  // R8
  walk_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inval_en_o && (state_d != ST_INVAL)) |-> (inval_idx_o == INDEX_W'(LINES - 1)));
endmodule

// File: rtl/ifetch_cache.sv
module ifetch_cache #(
  parameter logic [31:0] WIN_BASE   = 32'h0030_0000,
  parameter int          WIN_LOG2   = 16,
  parameter int          CACHE_LOG2 = 12,
  parameter int          LINE_WORDS = 8,
  localparam int         ADDR_W     = 32,
  localparam int         WSEL_W     = $clog2(LINE_WORDS),
  localparam int         LINE_LOG2  = WSEL_W + 2,
  localparam int         INDEX_W    = CACHE_LOG2 - LINE_LOG2,
  localparam int         TAG_W      = WIN_LOG2 - CACHE_LOG2,
  localparam int         DAW        = INDEX_W + WSEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inval_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              rsp_valid_o,
  output logic [31:0]       rsp_data_o,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_ack_i,
  input  logic [31:0]       mem_data_i
);
  logic [ADDR_W-1:0]  addr_q, addr_d;
  logic [31:0]        resp_q, resp_d;
  logic               cacheable, line_match, word_valid;
  logic [TAG_W-1:0]   tag;
  logic [INDEX_W-1:0] index, inval_idx;
  logic [WSEL_W-1:0]  wsel;
  logic               accept, hit, rsp_from_mem, alloc_en, wset_en, resp_we, inval_en;
  logic [31:0]        store_rdata;

  ifc_addr_split #(
    .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WIN_LOG2(WIN_LOG2),
    .CACHE_LOG2(CACHE_LOG2), .WSEL_W(WSEL_W)
  ) split_i (
    .waddr_i(addr_q[ADDR_W-1:2]), .cacheable_o(cacheable),
    .tag_o(tag), .index_o(index), .wsel_o(wsel)
  );

  ifc_tag_store #(.INDEX_W(INDEX_W), .TAG_W(TAG_W), .WSEL_W(WSEL_W)) tags_i (
    .clk(clk), .rst_n(rst_n), .idx_i(index), .tag_i(tag), .wsel_i(wsel),
    .alloc_en_i(alloc_en), .wset_en_i(wset_en), .inval_en_i(inval_en),
    .inval_idx_i(inval_idx), .line_match_o(line_match), .word_valid_o(word_valid)
  );

  ifc_data_store #(.AW(DAW), .DATA_W(32)) data_i (
    .clk(clk), .we_i(wset_en), .waddr_i({index, wsel}), .wdata_i(mem_data_i),
    .raddr_i({index, wsel}), .rdata_o(store_rdata)
  );

  ifc_ctrl #(.INDEX_W(INDEX_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .inval_i(inval_i), .req_valid_i(req_valid_i),
    .cacheable_i(cacheable), .line_match_i(line_match), .word_valid_i(word_valid),
    .mem_ack_i(mem_ack_i), .req_ready_o(req_ready_o), .accept_o(accept),
    .hit_o(hit), .rsp_from_mem_o(rsp_from_mem), .alloc_en_o(alloc_en),
    .wset_en_o(wset_en), .resp_we_o(resp_we), .inval_en_o(inval_en),
    .inval_idx_o(inval_idx), .mem_rd_o(mem_rd_o)
  );

  always_comb begin
    addr_d      = accept  ? req_addr_i : addr_q;
    resp_d      = resp_we ? mem_data_i : resp_q;
    rsp_valid_o = hit || rsp_from_mem;
    rsp_data_o  = rsp_from_mem ? resp_q : store_rdata;
    mem_addr_o  = addr_q & ~ADDR_W'(3);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      resp_q <= '0;
    end else begin
      addr_q <= addr_d;
      resp_q <= resp_d;
    end
  end

  // R9
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_o && !mem_ack_i) |=> $stable(mem_addr_o));
  // R3
  hit_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> !mem_rd_o);
endmodule

// File: tb/ifetch_cache_tb_top.sv
module ifetch_cache_tb_top;
  localparam logic [31:0] BASE  = 32'h0030_0000;
  localparam int          LINES = 128;
  localparam int          WPL   = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inval_i = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [31:0] req_addr_i = '0;
  logic        mem_ack_i = 1'b0;
  logic [31:0] mem_data_i = '0;
  logic        req_ready_o, rsp_valid_o, mem_rd_o;
  logic [31:0] rsp_data_o, mem_addr_o;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int mem_reads = 0;
  int ack_cyc = 0;
  int dly = 0;
  logic [31:0] rd_addr_seen;

  bit       m_lv [LINES];
  bit [3:0] m_tag [LINES];
  bit [WPL-1:0] m_wv [LINES];

  ifetch_cache dut_i (
    .clk(clk), .rst_n(rst_n), .inval_i(inval_i), .req_valid_i(req_valid_i),
    .req_ready_o(req_ready_o), .req_addr_i(req_addr_i), .rsp_valid_o(rsp_valid_o),
    .rsp_data_o(rsp_data_o), .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o),
    .mem_ack_i(mem_ack_i), .mem_data_i(mem_data_i)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    logic [31:0] w;
    w = {a[31:2], 2'b00};
    return (w * 32'h9E37_79B1) ^ 32'h5A3C_9617 ^ {w[15:0], w[31:16]};
  endfunction

  function automatic bit in_win(input logic [31:0] a);
    return a[31:16] == BASE[31:16];
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model: random latency 0..2 cycles, data from mem_word
  always @(negedge clk) begin
    if (mem_ack_i) begin
      mem_ack_i = 1'b0;
    end else if (mem_rd_o) begin
      if (dly == 0) begin
        mem_ack_i  = 1'b1;
        mem_data_i = mem_word(mem_addr_o);
        rd_addr_seen = mem_addr_o;
        mem_reads++;
        ack_cyc = cyc;
        dly = $urandom % 3;
      end else begin
        dly--;
      end
    end
  end

  task automatic fetch(input logic [31:0] a);
    bit exp_hit, cach, lm, rdy;
    int r0, t0, rc;
    int idx, wd;
    bit [3:0] tg;
    string rq;
    idx = a[11:5]; wd = a[4:2]; tg = a[15:12];
    cach = in_win(a);
    lm = cach && m_lv[idx] && (m_tag[idx] == tg);
    exp_hit = lm && m_wv[idx][wd];
    if (!cach) rq = "R7 bypass";
    else if (exp_hit) rq = "R3 hit";
    else if (!lm) rq = "R4 realloc";
    else rq = "R5 word miss";
    r0 = mem_reads;
    @(negedge clk);
    req_valid_i = 1'b1;
    req_addr_i  = a;
    do begin
      #1 rdy = req_ready_o;
      @(posedge clk);
      if (!rdy) @(negedge clk);
    end while (!rdy);
    @(negedge clk);
    req_valid_i = 1'b0;
    t0 = cyc;
    while (!rsp_valid_o) @(negedge clk);
    rc = cyc;
    check(rsp_data_o == mem_word(a), rq, rsp_data_o, mem_word(a));
    check((mem_reads - r0) == (exp_hit ? 0 : 1), rq, mem_reads - r0, exp_hit ? 0 : 1);
    if (exp_hit)
      check(rc == t0, "R3 latency", rc - t0 + 1, 1);
    else begin
      check(rc == ack_cyc + 1, "R6 latency after ack", rc - ack_cyc, 1);
      check(rd_addr_seen == {a[31:2], 2'b00}, "R9 mem addr", rd_addr_seen, {a[31:2], 2'b00});
    end
    if (cach && !exp_hit) begin
      if (!lm) begin m_lv[idx] = 1'b1; m_tag[idx] = tg; m_wv[idx] = '0; end
      m_wv[idx][wd] = 1'b1;
    end
  endtask

  task automatic invalidate();
    int low;
    @(negedge clk);
    inval_i = 1'b1;
    low = 0;
    #1 if (!req_ready_o) low++;
    @(negedge clk);
    inval_i = 1'b0;
    #1;
    while (!req_ready_o) begin
      low++;
      @(negedge clk);
      #1;
    end
    check(low == LINES + 1, "R8 busy cycles", low, LINES + 1);
    for (int i = 0; i < LINES; i++) m_lv[i] = 1'b0;
  endtask

  function automatic logic [31:0] rand_addr();
    int r;
    r = $urandom % 10;
    if (r < 6) return BASE | (($urandom % 4) << 12) | (($urandom % 8) << 5) | (($urandom % 8) << 2) | ($urandom % 4);
    else if (r < 8) return 32'h0040_0000 | (($urandom % 64) << 2);
    else if (r == 8) return BASE - 4;
    else return BASE + 32'h0000_FFFC;
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < LINES; i++) m_lv[i] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    // R10 reset state
    check(req_ready_o == 1'b1, "R10 ready", req_ready_o, 1);
    check(rsp_valid_o == 1'b0, "R10 rsp_valid", rsp_valid_o, 0);
    check(mem_rd_o == 1'b0, "R10 mem_rd", mem_rd_o, 0);

    // R4/R3/R5 on one line, then R2 aliasing eviction
    fetch(BASE + 32'h40);
    fetch(BASE + 32'h40);
    fetch(BASE + 32'h44);
    fetch(BASE + 32'h40);
    fetch(BASE + 32'h44);
    fetch(BASE + 32'h1040);
    fetch(BASE + 32'h44);
    fetch(BASE + 32'h1040);
    // R1 boundaries, R7 bypass aliasing a cached index leaves it cached
    fetch(BASE - 4);
    fetch(BASE - 4);
    fetch(BASE);
    fetch(BASE + 32'hFFFC);
    fetch(BASE + 32'hFFFC);
    fetch(BASE + 32'h1_0040);
    fetch(BASE + 32'h1_0040);
    fetch(BASE + 32'h1040);
    // R9 unaligned request
    fetch(BASE + 32'h102);
    fetch(BASE + 32'h103);
    // R8 invalidate, then cached addresses miss
    invalidate();
    fetch(BASE + 32'h1040);
    fetch(BASE + 32'hFFFC);

    for (int n = 0; n < 600; n++) begin
      fetch(rand_addr());
      if (n % 150 == 149) invalidate();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule